// File: doc/BRIEF.md
# Credit-Gated Stream Source

This block drives the transmit side of a streaming link whose flow control works by credits granted in advance, not by a per-cycle ready. The far end grants credit by asserting an update strobe with a credit amount on a small bus. The block keeps a running credit count. It lets one upstream beat through for each credit it holds. Each beat carries data plus start-of-packet and end-of-packet flags, and a valid strobe qualifies all of them.

Upstream beats arrive on a ready/valid interface. The beat path is combinational: when a credit is held, the upstream beat appears on the link in the same cycle, and the count drops by one on the next clock edge.

If credits sit unused while upstream has nothing to send, the block gives them back to the far end. It does this one at a time, with a single-cycle return strobe after a fixed number of consecutive idle cycles. This lets the far end use that buffer space elsewhere. The credit path and the data path may have unequal delays, so credit bookkeeping never depends on when beats arrive at the far end.

Top module: `credit_stream_source`

## Requirements
- R1: During and straight after reset the block holds zero credits, and `up_ready`, `lk_valid` and `lk_crd_return` are all 0.
- R2: A cycle with `lk_crd_update` = 1 adds the unsigned value on `lk_crd_value` to the credit count, effective from the next cycle.
- R3: `lk_valid` is 1 only when `up_valid` is 1 and the count is at least one. `up_ready` is 1 exactly when the count is at least one.
- R4: Each cycle with `lk_valid` = 1 consumes exactly one credit. With no further updates, a count of N admits exactly N beats.
- R5: A beat in the same cycle as an update changes the count by the update value minus one.
- R6: `lk_data`, `lk_sop` and `lk_eop` equal `up_data`, `up_sop` and `up_eop` in every cycle that `lk_valid` is 1.
- R7: After IDLE_LIMIT (default 4) consecutive cycles with credit held and `up_valid` = 0, `lk_crd_return` pulses for one cycle on the last of them and one credit is removed. The pulse repeats every IDLE_LIMIT idle cycles until the count is zero.
- R8: A cycle with `up_valid` = 1 restarts the idle count. `lk_crd_return` is never 1 in a cycle with `up_valid` = 1 or with zero credits.
- R9: The count never exceeds MAX_CREDIT (default 8). The far end must not grant past it, and an excess grant is clipped at MAX_CREDIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Upstream beat present |
| up_ready | output | 1 | Block can take an upstream beat (credit held) |
| up_data | input | DATA_W | Upstream beat payload |
| up_sop | input | 1 | Upstream start-of-packet flag |
| up_eop | input | 1 | Upstream end-of-packet flag |
| lk_valid | output | 1 | Link beat valid; qualifies data and flags |
| lk_data | output | DATA_W | Link beat payload |
| lk_sop | output | 1 | Link start-of-packet flag |
| lk_eop | output | 1 | Link end-of-packet flag |
| lk_crd_update | input | 1 | Far end grants credit this cycle |
| lk_crd_value | input | CRD_W | Number of credits granted |
| lk_crd_return | output | 1 | One-cycle strobe giving one credit back |

## Verification
Beat gating and return strobes are combinational on the current inputs and the registered count, so they are due in the same cycle as the stimulus. A credit change from a grant, a beat or a return is due one clock edge later. The bench drives inputs on the falling edge and samples 2 ns afterwards, before the next rising edge. It then sees the count that the previous rising edge produced. An idle return is due on the IDLE_LIMIT-th quiet cycle after the first cycle with nonzero credit, and the bench counts cycles from that grant to place its checks.

// File: rtl/crsrc_pkg.sv
// Package: shared constants and helpers for the credit-gated stream source.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package crsrc_pkg;

    // Width needed to hold the values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    // Larger of two widths, for intermediate sums.
    function automatic int unsigned max_width(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/crsrc_credit_ctr.sv
// Module: credit counter. Adds grants, removes one credit per beat or return.
// Assumes: beat and return are never requested in the same cycle, and the far end
// never grants past MAX_CREDIT. An excess is clipped and flagged by an assertion.
module crsrc_credit_ctr
    import crsrc_pkg::*;
#(
    parameter int unsigned MAX_CREDIT = 8,
    parameter int unsigned CRD_W      = 4,
    parameter int unsigned CNT_W      = cnt_width(MAX_CREDIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  logic [CRD_W-1:0] grant_amt,
    input  logic             take_beat,
    input  logic             take_ret,
    output logic [CNT_W-1:0] count,
    output logic             has_credit
);
    localparam int unsigned SUM_W = max_width(CNT_W, CRD_W) + 1;

    logic [SUM_W-1:0] sum_raw;
    logic [SUM_W-1:0] sum_next;

    // Next count: grant in, one credit out on beat or return, clip at the maximum.
    always_comb begin
        sum_raw = SUM_W'(count) + (grant ? SUM_W'(grant_amt) : SUM_W'(0));
        if (take_beat || take_ret) begin
            sum_raw = sum_raw - SUM_W'(1);
        end
        sum_next = (sum_raw > SUM_W'(MAX_CREDIT)) ? SUM_W'(MAX_CREDIT) : sum_raw;
    end

    // Count register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= CNT_W'(sum_next);
        end
    end

    // Credit-present flag used by the beat gate and the return logic.
    assign has_credit = (count != '0);

    // R9: the far end never pushes the count past the maximum.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (int'(count) + int'(grant_amt) - int'(take_beat)) <= int'(MAX_CREDIT));

    // R4: a lone beat removes exactly one credit.
    p_beat_decrements_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_beat && !grant) |=> (count == $past(count) - CNT_W'(1)));

    // R5: a beat together with a grant nets the grant minus one.
    p_grant_and_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_beat && grant && (int'(count) + int'(grant_amt) <= int'(MAX_CREDIT)))
        |=> (int'(count) == int'($past(count)) + int'($past(grant_amt)) - 1));

    // R3: a credit is never taken from an empty count.
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_beat || take_ret) |-> has_credit);

endmodule

// File: rtl/crsrc_beat_gate.sv
// Module: beat gate. Passes an upstream beat to the link only while credit is held.
// Assumes: has_credit comes from a registered count, so there is no combinational loop.
module crsrc_beat_gate #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              has_credit,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    input  logic              up_sop,
    input  logic              up_eop,
    output logic              lk_valid,
    output logic [DATA_W-1:0] lk_data,
    output logic              lk_sop,
    output logic              lk_eop,
    output logic              beat_fire
);
    // Gate valid with credit and forward payload and packet flags unchanged.
    always_comb begin
        up_ready  = has_credit;
        lk_valid  = up_valid && has_credit;
        lk_data   = up_data;
        lk_sop    = up_sop;
        lk_eop    = up_eop;
        beat_fire = lk_valid;
    end
endmodule

// File: rtl/crsrc_return_ctl.sv
// Module: idle return control. Counts quiet cycles with credit held and gives one
// credit back each IDLE_LIMIT of them.
// Assumes: IDLE_LIMIT >= 1; up_valid is the raw upstream request.
module crsrc_return_ctl
    import crsrc_pkg::*;
#(
    parameter int unsigned IDLE_LIMIT = 4,
    parameter int unsigned IDLE_W     = cnt_width(IDLE_LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_valid,
    input  logic has_credit,
    output logic ret_fire
);
    logic [IDLE_W-1:0] idle_cnt;

    // Fire on the last quiet cycle of the window.
    assign ret_fire = !up_valid && has_credit && (idle_cnt == IDLE_W'(IDLE_LIMIT - 1));

    // Idle counter: restarts on traffic, on empty credit and after each return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (up_valid || !has_credit || ret_fire) begin
            idle_cnt <= '0;
        end else begin
            idle_cnt <= idle_cnt + IDLE_W'(1);
        end
    end

    // R8: no return while upstream has a beat pending or with no credit.
    p_ret_only_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |-> (!up_valid && has_credit));

    // R8: upstream traffic restarts the idle window.
    p_idle_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> (idle_cnt == '0));

    // R7: a return is a single-cycle pulse.
    p_ret_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |=> !ret_fire);

endmodule

// File: rtl/credit_stream_source.sv
// Module: credit-gated stream source (top). Joins the credit counter, the beat gate
// and the idle return control.
// Assumes: synchronous active-low reset; the far end honours MAX_CREDIT.
module credit_stream_source
    import crsrc_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned MAX_CREDIT = 8,
    parameter int unsigned CRD_W      = 4,
    parameter int unsigned IDLE_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    input  logic              up_sop,
    input  logic              up_eop,
    output logic              lk_valid,
    output logic [DATA_W-1:0] lk_data,
    output logic              lk_sop,
    output logic              lk_eop,
    input  logic              lk_crd_update,
    input  logic [CRD_W-1:0]  lk_crd_value,
    output logic              lk_crd_return
);
    localparam int unsigned CNT_W = cnt_width(MAX_CREDIT);

    logic [CNT_W-1:0] credit_cnt;
    logic             has_credit;
    logic             beat_fire;
    logic             ret_fire;

    crsrc_credit_ctr #(
        .MAX_CREDIT (MAX_CREDIT),
        .CRD_W      (CRD_W),
        .CNT_W      (CNT_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant      (lk_crd_update),
        .grant_amt  (lk_crd_value),
        .take_beat  (beat_fire),
        .take_ret   (ret_fire),
        .count      (credit_cnt),
        .has_credit (has_credit)
    );

    crsrc_beat_gate #(
        .DATA_W (DATA_W)
    ) u_gate (
        .has_credit (has_credit),
        .up_valid   (up_valid),
        .up_ready   (up_ready),
        .up_data    (up_data),
        .up_sop     (up_sop),
        .up_eop     (up_eop),
        .lk_valid   (lk_valid),
        .lk_data    (lk_data),
        .lk_sop     (lk_sop),
        .lk_eop     (lk_eop),
        .beat_fire  (beat_fire)
    );

    crsrc_return_ctl #(
        .IDLE_LIMIT (IDLE_LIMIT)
    ) u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_valid   (up_valid),
        .has_credit (has_credit),
        .ret_fire   (ret_fire)
    );

    assign lk_crd_return = ret_fire;

    // R3: the link never carries a beat without a credit behind it.
    p_beat_needs_credit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (credit_cnt != '0));

    // R9: the count stays within its limit.
    p_count_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(credit_cnt) <= int'(MAX_CREDIT));

    // R1: the cycle after reset starts with an empty count.
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (credit_cnt == '0));

endmodule

// File: tb/test_credit_stream_source.sv
// Bench: a vector table walked by one loop, then directed tests with a sink model.
module test_credit_stream_source;
    localparam int DATA_W = 8;
    localparam int CRD_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              up_valid = 1'b0;
    logic              up_ready;
    logic [DATA_W-1:0] up_data = '0;
    logic              up_sop = 1'b0;
    logic              up_eop = 1'b0;
    logic              lk_valid;
    logic [DATA_W-1:0] lk_data;
    logic              lk_sop;
    logic              lk_eop;
    logic              lk_crd_update = 1'b0;
    logic [CRD_W-1:0]  lk_crd_value = '0;
    logic              lk_crd_return;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;
    int granted  = 0;
    int received = 0;
    int returned = 0;

    always #5 clk = ~clk;

    credit_stream_source i_credit_stream_source (
        .clk (clk), .rst_n (rst_n),
        .up_valid (up_valid), .up_ready (up_ready), .up_data (up_data),
        .up_sop (up_sop), .up_eop (up_eop),
        .lk_valid (lk_valid), .lk_data (lk_data), .lk_sop (lk_sop), .lk_eop (lk_eop),
        .lk_crd_update (lk_crd_update), .lk_crd_value (lk_crd_value),
        .lk_crd_return (lk_crd_return)
    );

    // Vector: {up_valid, update, value[3:0], expected lk_valid, expected return}
    localparam logic [7:0] VEC [15] = '{
        {1'b1, 1'b0, 4'd0, 1'b0, 1'b0},   // R3 no credit
        {1'b1, 1'b1, 4'd3, 1'b0, 1'b0},   // R2 grant 3, still empty this cycle
        {1'b1, 1'b0, 4'd0, 1'b1, 1'b0},   // R4 beat, 3->2
        {1'b1, 1'b1, 4'd2, 1'b1, 1'b0},   // R5 beat+grant2, 2->3
        {1'b1, 1'b0, 4'd0, 1'b1, 1'b0},   // 3->2
        {1'b1, 1'b0, 4'd0, 1'b1, 1'b0},   // 2->1
        {1'b1, 1'b0, 4'd0, 1'b1, 1'b0},   // 1->0
        {1'b1, 1'b0, 4'd0, 1'b0, 1'b0},   // R4 exhausted
        {1'b0, 1'b1, 4'd1, 1'b0, 1'b0},   // grant 1
        {1'b0, 1'b0, 4'd0, 1'b0, 1'b0},   // idle 1
        {1'b0, 1'b0, 4'd0, 1'b0, 1'b0},   // idle 2
        {1'b0, 1'b0, 4'd0, 1'b0, 1'b0},   // idle 3
        {1'b0, 1'b0, 4'd0, 1'b0, 1'b1},   // R7 idle 4 -> return
        {1'b0, 1'b0, 4'd0, 1'b0, 1'b0},   // R8 empty, no return
        {1'b1, 1'b0, 4'd0, 1'b0, 1'b0}    // R7 returned credit is gone
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    // Drive one cycle's inputs on the falling edge; sampling follows 2 ns later.
    task automatic drive(input logic v, input logic u, input logic [3:0] val,
                         input logic [DATA_W-1:0] d, input logic s, input logic e);
        @(negedge clk);
        up_valid = v; lk_crd_update = u; lk_crd_value = val;
        up_data = d; up_sop = s; up_eop = e;
        #2;
        if (u) granted += int'(val);
        if (lk_valid) received++;
        if (lk_crd_return) returned++;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int pulses;
        // R1: reset state
        repeat (3) @(negedge clk);
        #2;
        check("R1 up_ready in reset", up_ready, 0);
        check("R1 lk_valid in reset", lk_valid, 0);
        check("R1 return in reset", lk_crd_return, 0);
        @(negedge clk); rst_n = 1'b1; up_valid = 1'b1;
        #2;
        check("R1 no credit after reset", up_ready, 0);
        check("R1 no beat after reset", lk_valid, 0);

        // Vector table
        for (int i = 0; i < 15; i++) begin
            drive(VEC[i][7], VEC[i][6], VEC[i][5:2], DATA_W'(i), 1'b0, 1'b0);
            check($sformatf("R3/R4/R5/R7 vec %0d lk_valid", i), lk_valid, VEC[i][1]);
            check($sformatf("R7/R8 vec %0d return", i), lk_crd_return, VEC[i][0]);
        end

        // R2/R4/R6: grant 8, send a packet of 8 beats, 9th blocked
        drive(1'b0, 1'b1, 4'd8, '0, 1'b0, 1'b0);
        for (int b = 0; b < 8; b++) begin
            drive(1'b1, 1'b0, 4'd0, DATA_W'(8'hA0 + b), b == 0, b == 7);
            check("R2 beat admitted", lk_valid, 1);
            check("R6 data", lk_data, 8'hA0 + b);
            check("R6 sop", lk_sop, b == 0);
            check("R6 eop", lk_eop, b == 7);
        end
        drive(1'b1, 1'b0, 4'd0, 8'h55, 1'b0, 1'b0);
        check("R4 ninth beat blocked", lk_valid, 0);
        check("R3 up_ready low when empty", up_ready, 0);

        // R7: grant 3 then idle; returns on quiet cycles 4, 8, 12
        drive(1'b0, 1'b1, 4'd3, '0, 1'b0, 1'b0);
        pulses = 0;
        for (int c = 1; c <= 16; c++) begin
            drive(1'b0, 1'b0, 4'd0, '0, 1'b0, 1'b0);
            check("R7 return timing", lk_crd_return, (c % 4 == 0) && (c <= 12));
            if (lk_crd_return) pulses++;
        end
        check("R7 all three returned", pulses, 3);
        check("R7 no credit left", up_ready, 0);

        // R8: a beat mid-window restarts the idle count
        drive(1'b0, 1'b1, 4'd2, '0, 1'b0, 1'b0);
        for (int c = 0; c < 3; c++) begin
            drive(1'b0, 1'b0, 4'd0, '0, 1'b0, 1'b0);
            check("R8 no early return", lk_crd_return, 0);
        end
        drive(1'b1, 1'b0, 4'd0, 8'h11, 1'b1, 1'b1);
        check("R8 beat instead of return", lk_valid, 1);
        check("R8 no return with up_valid", lk_crd_return, 0);
        for (int c = 1; c <= 4; c++) begin
            drive(1'b0, 1'b0, 4'd0, '0, 1'b0, 1'b0);
            check("R8 restarted window", lk_crd_return, c == 4);
        end

        // Sink model balance: every granted credit came back as a beat or a return
        check("R4 credit balance", received + returned, granted);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule